// File: doc/BRIEF.md
# Single-Cycle Rising Edge Pulse Generator

This block watches a single-bit input that is already synchronous to its clock and produces a pulse one clock cycle wide each time that input goes from 0 to 1. It is meant for control paths that need to act once per assertion of a level signal, such as a button that has already been synchronised or a request line. The input may stay high for a long time, but the block still produces only one pulse for that assertion.

A build-time parameter selects one of two state machines.

- **Mealy form (`MOORE = 0`).** Two states track the input value from the previous cycle. The output combines that state with the current input, so the pulse appears in the same cycle as the edge.
- **Moore form (`MOORE = 1`).** Three states are used: idle, fire and hold. The output is decoded from the state alone, so it is glitch-free and comes straight from a register. The cost is a pulse that appears exactly one cycle later than in the Mealy form.

Both forms return to idle on a synchronous, active-high reset.

Top module: `rise_pulse_fsm`

## Requirements
- R1: After a clock edge sampled with `rst_i` high, both forms are in their idle state, and the Moore form drives `pulse_o` low.
- R2: In the Mealy form (`MOORE = 0`), `pulse_o` equals `sig_i` AND NOT the value of `sig_i` sampled at the previous clock edge, within the same cycle.
- R3: In the Moore form (`MOORE = 1`), `pulse_o` is high in exactly the cycle that follows the cycle in which the Mealy form would pulse, and it depends on the state only.
- R4: An input held high for any number of cycles produces exactly one pulse.
- R5: Every pulse is exactly one clock cycle wide.
- R6: An input that alternates 1,0,1,0 on successive cycles produces one pulse for every 0-to-1 transition, with none missed.
- R7: In the Moore form, a low input in the fire state returns the machine to idle, so a rising edge two cycles later pulses again. A high input in the fire state moves it to hold, where it stays while the input remains high.
- R8: An input that is already high while reset is held, and still high at release, counts as a rising edge in the first cycle after release.
- R9: A reset sampled while the Moore form is in its fire state ends the pulse at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| sig_i | input | 1 | Level input whose 0-to-1 transitions are detected |
| pulse_o | output | 1 | One-cycle pulse per detected rising edge |

## Verification
Both forms are driven from the same stimulus. This lets the one-cycle lag between the Mealy and Moore outputs be compared directly for every pattern.

- **Isolated edge.** Gives the basic timing of each form.
- **Long high level.** Separates level detection from edge detection.
- **Input alternating every cycle.** Shows whether the Moore fire state can re-arm without missing an edge.
- **Patterns 1,0,1 and 1,1,0.** Distinguish the two exits from the fire state.
- **High input across a reset release, and a reset during a pulse.** Pin down how the start-up state is defined.

// File: rtl/rise_pulse_fsm.sv
module rise_pulse_fsm #(
  parameter bit MOORE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sig_i,
  output logic pulse_o
);

  logic [1:0] rst_hist;
  logic       chk_off;

  always_ff @(posedge clk_i) rst_hist <= {rst_hist[0], rst_i};
  assign chk_off = rst_i || (rst_hist != 2'b00);

  generate
    if (MOORE) begin : g_moore
      typedef enum logic [1:0] {M_IDLE = 2'd0, M_FIRE = 2'd1, M_HOLD = 2'd2} mst_t;
      mst_t st, st_nx;

      always_comb begin
        st_nx = st;
        case (st)
          M_IDLE:  if (sig_i)  st_nx = M_FIRE;
          M_FIRE:  st_nx = sig_i ? M_HOLD : M_IDLE;
          M_HOLD:  if (!sig_i) st_nx = M_IDLE;
          default: st_nx = M_IDLE;
        endcase
      end

      always_ff @(posedge clk_i) begin
        if (rst_i) st <= M_IDLE;
        else       st <= st_nx;
      end

      assign pulse_o = (st == M_FIRE);

      AST_MOORE_RESET_IDLE: assert property (@(posedge clk_i) rst_i |=> (st == M_IDLE && !pulse_o)); // R1
      AST_MOORE_LAG: assert property (@(posedge clk_i) disable iff (chk_off)
        pulse_o == ($past(sig_i) && !$past(sig_i, 2))); // R3
      AST_MOORE_QUIET_HIGH: assert property (@(posedge clk_i) disable iff (chk_off)
        (sig_i && $past(sig_i) && $past(sig_i, 2)) |-> !pulse_o); // R4
      AST_MOORE_REARM: assert property (@(posedge clk_i) disable iff (rst_i)
        (st == M_FIRE && !sig_i) |=> (st == M_IDLE)); // R7
      AST_MOORE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (st != M_IDLE && sig_i) |=> (st == M_HOLD)); // R7
      AST_MOORE_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
        (st != 2'd3)); // R3
    end else begin : g_mealy
      typedef enum logic {L_LOW = 1'b0, L_HIGH = 1'b1} lst_t;
      lst_t st;

      always_ff @(posedge clk_i) begin
        if (rst_i) st <= L_LOW;
        else       st <= sig_i ? L_HIGH : L_LOW;
      end

      assign pulse_o = sig_i && (st == L_LOW);

      AST_MEALY_RESET_IDLE: assert property (@(posedge clk_i) rst_i |=> (st == L_LOW)); // R1
      AST_MEALY_EDGE: assert property (@(posedge clk_i) disable iff (chk_off)
        pulse_o == (sig_i && !$past(sig_i))); // R2
      AST_MEALY_QUIET_HIGH: assert property (@(posedge clk_i) disable iff (chk_off)
        (sig_i && $past(sig_i)) |-> !pulse_o); // R4
      AST_MEALY_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> sig_i); // R2
    end
  endgenerate

  AST_ONE_CYCLE_WIDE: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o |=> !pulse_o); // R5

endmodule

// File: tb/rise_pulse_fsm_tb_top.sv
`timescale 1ns/1ps
module rise_pulse_fsm_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig = 1'b0;
  logic p_mealy, p_moore;

  int n_chk  = 0;
  int n_fail = 0;
  int cnt_mealy = 0;
  int cnt_moore = 0;

  logic prev_m    = 1'b0;
  logic moore_exp = 1'b0;

  always #5 clk = ~clk;

  rise_pulse_fsm #(.MOORE(1'b0)) dut_i (
    .clk_i(clk), .rst_i(rst), .sig_i(sig), .pulse_o(p_mealy));

  rise_pulse_fsm #(.MOORE(1'b1)) dut_moore_i (
    .clk_i(clk), .rst_i(rst), .sig_i(sig), .pulse_o(p_moore));

  always @(posedge clk) begin
    prev_m    <= rst ? 1'b0 : sig;
    moore_exp <= rst ? 1'b0 : (sig && !prev_m);
  end

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic r, input string tag);
    @(negedge clk);
    sig = v;
    rst = r;
    #2;
    if (!r) begin
      chk(p_mealy, sig && !prev_m, {tag, " mealy"});
      if (p_mealy) cnt_mealy++;
    end
    chk(p_moore, moore_exp, {tag, " moore"});
    if (p_moore && !r) cnt_moore++;
  endtask

  task automatic clear_counts();
    cnt_mealy = 0;
    cnt_moore = 0;
  endtask

  task automatic t_reset();
    repeat (3) step(1'b0, 1'b1, "R1 in reset");
    chk(p_moore, 1'b0, "R1 moore low in reset");
    step(1'b0, 1'b0, "R1 after release");
    step(1'b1, 1'b0, "R1 first edge");
    step(1'b0, 1'b0, "R1 lagged");
    step(1'b0, 1'b0, "R1 idle");
  endtask

  task automatic t_single_edge();
    clear_counts();
    step(1'b0, 1'b0, "R2 low");
    step(1'b1, 1'b0, "R2 edge");
    chk(p_mealy, 1'b1, "R2 mealy same cycle");
    chk(p_moore, 1'b0, "R3 moore not yet");
    step(1'b0, 1'b0, "R3 lag");
    chk(p_moore, 1'b1, "R3 moore one cycle later");
    step(1'b0, 1'b0, "R5 width");
    chk(p_moore, 1'b0, "R5 moore one wide");
    chk_int(cnt_mealy, 1, "R5 mealy pulse count");
    chk_int(cnt_moore, 1, "R5 moore pulse count");
  endtask

  task automatic t_hold_high();
    clear_counts();
    step(1'b0, 1'b0, "R4 low");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, "R4 held");
    step(1'b0, 1'b0, "R4 drop");
    step(1'b0, 1'b0, "R4 low");
    chk_int(cnt_mealy, 1, "R4 mealy single pulse");
    chk_int(cnt_moore, 1, "R4 moore single pulse");
  endtask

  task automatic t_toggle();
    clear_counts();
    step(1'b0, 1'b0, "R6 low");
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b0, "R6 rise");
      step(1'b0, 1'b0, "R6 fall");
    end
    step(1'b0, 1'b0, "R6 tail");
    chk_int(cnt_mealy, 6, "R6 mealy every edge");
    chk_int(cnt_moore, 6, "R6 moore every edge");
  endtask

  task automatic t_rearm();
    clear_counts();
    step(1'b0, 1'b0, "R7 low");
    step(1'b1, 1'b0, "R7 rise a");
    step(1'b0, 1'b0, "R7 fire then low");
    step(1'b1, 1'b0, "R7 rise b");
    step(1'b1, 1'b0, "R7 fire then high");
    step(1'b1, 1'b0, "R7 hold");
    step(1'b0, 1'b0, "R7 drop");
    step(1'b0, 1'b0, "R7 idle");
    chk_int(cnt_moore, 2, "R7 moore two pulses");
    chk_int(cnt_mealy, 2, "R7 mealy two pulses");
  endtask

  task automatic t_high_at_release();
    step(1'b1, 1'b1, "R8 high in reset");
    step(1'b1, 1'b1, "R8 high in reset");
    step(1'b1, 1'b0, "R8 release high");
    chk(p_mealy, 1'b1, "R8 mealy pulses at release");
    step(1'b1, 1'b0, "R8 still high");
    chk(p_moore, 1'b1, "R8 moore pulses after release");
    step(1'b1, 1'b0, "R8 hold");
    chk(p_moore, 1'b0, "R8 moore single");
    step(1'b0, 1'b0, "R8 drop");
  endtask

  task automatic t_mid_reset();
    step(1'b0, 1'b0, "R9 low");
    step(1'b1, 1'b0, "R9 rise");
    step(1'b1, 1'b1, "R9 reset during fire");
    chk(p_moore, 1'b1, "R9 moore fire before reset edge");
    step(1'b0, 1'b1, "R9 reset held");
    chk(p_moore, 1'b0, "R9 moore cleared by reset");
    step(1'b0, 1'b0, "R9 released");
    step(1'b0, 1'b0, "R9 idle");
  endtask

  initial begin
    t_reset();
    t_single_edge();
    t_hold_high();
    t_toggle();
    t_rearm();
    t_high_at_release();
    t_mid_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule